// File: doc/BRIEF.md
# Watchdog Timer on an Independent Clock

This block is a watchdog that counts on its own clock input, separate from the system clock. It keeps counting while the system clock is gated off during sleep. Software restarts the count with a clear request, which a clear-watchdog instruction raises for one system clock. If the count runs out while the system is awake, the block raises a one-cycle reset request in the system clock domain. If the count runs out while the system is asleep, the block raises a wake request instead. The wake request is a register in the watchdog domain, so the sleep controller can act on it without a running system clock.

The timeout period is set by an 8-bit base counter and a 7-bit prescaler in front of it. A 3-bit ratio field selects a division of 2^ratio, so the base counter advances once every 1 to 128 watchdog clocks.

Three signals cross between the clock domains:
- The clear request reaches the watchdog domain as a toggle through a two-flop synchroniser.
- Each timeout returns to the system domain as a toggle, where it sets a sticky status flag. Software reads this flag to tell a watchdog reset from a power-on reset.
- The sleep state reaches the watchdog domain through a two-flop synchroniser.

A parameter removes the whole function and holds every output low.

Top module: `wdog_top`

## Requirements
- R1: While `por` is high, and on the first clock of each domain after it, `wd_reset`, `to_flag` and `wake` are 0. `por` must stay high for at least two watchdog clocks.
- R2: The number of watchdog clocks from the clear (or from the end of `por`) to the timeout is 256 × 2^`ratio_sel`. `ratio_sel` is a 3-bit unsigned value from 0 to 7 and must be stable for 3 watchdog clocks before the clear.
- R3: A clear request restarts the count. The restart takes effect on the third watchdog clock edge after the system clock edge that samples `clr_req` high. While clears arrive more often than the timeout period, no timeout occurs.
- R4: A timeout while the synchronised `asleep` is 0 gives a `wd_reset` pulse of exactly one system clock. The pulse starts after the third system clock edge that follows the timeout edge.
- R5: A timeout while the synchronised `asleep` is 1 sets `wake` right after the timeout edge and produces no `wd_reset` pulse.
- R6: `wake` stays at 1 while `asleep` is 1. It returns to 0 on the third watchdog clock edge after `asleep` falls.
- R7: Every timeout sets `to_flag` in the same system cycle in which R4 would issue the pulse. The flag stays set until `clr_req` or `por`. If a timeout arrives in the same cycle as a clear, the timeout wins.
- R8: Counting and the wake request work with `sys_clk` stopped. A timeout that happened during the stop reaches `to_flag` after the clock restarts.
- R9: With the parameter `EN` = 0, all three outputs stay 0 for any stimulus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sys_clk | input | 1 | System clock; may be stopped during sleep |
| wd_clk | input | 1 | Dedicated watchdog clock |
| por | input | 1 | Power-on reset, active high, sampled by both clocks |
| clr_req | input | 1 | One-cycle clear request (system domain) |
| ratio_sel | input | RATIO_W | Prescaler ratio, division by 2^ratio_sel |
| asleep | input | 1 | High while the system is in sleep mode |
| wd_reset | output | 1 | One-cycle reset request (system domain) |
| wake | output | 1 | Wake request (watchdog domain) |
| to_flag | output | 1 | Sticky timeout status (system domain) |

## Verification
A counter or prescaler that drifts shows up as a timeout edge that moves. The move is visible in the `wake` or `wd_reset` cycle one period later, and the bench compares that cycle exactly. A lost or doubled toggle in either synchroniser shows up within three clocks of the receiving domain. It appears as a missing restart, a missing or repeated `wd_reset`, or a `to_flag` that does not follow the event. A wrong reset-versus-wake decision shows up on the timeout edge itself, as a pulse during sleep or a `wake` while awake. The sleep case is run with `sys_clk` stopped.

// File: rtl/wdog_pkg.sv
`timescale 1ns/100ps
package wdog_pkg;
  // What the watchdog domain recorded at its latest timeout.
  typedef enum logic {
    TO_RESET = 1'b0,
    TO_WAKE  = 1'b1
  } to_kind_e;
endpackage

// File: rtl/wdog_sync.sv
`timescale 1ns/100ps
// Flop chain used to bring a signal into the clock domain of clk.
module wdog_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      stg <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/wdog_tgl_rx.sv
`timescale 1ns/100ps
// Receives a toggle from another domain and turns each change into a one-cycle pulse.
module wdog_tgl_rx #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic tgl,
  output logic pulse
);
  logic tgl_s;
  logic tgl_prev;

  wdog_sync #(.W(1), .STAGES(STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (tgl),
    .q   (tgl_s)
  );

  always_ff @(posedge clk) begin
    if (rst) tgl_prev <= 1'b0;
    else     tgl_prev <= tgl_s;
  end

  assign pulse = tgl_s ^ tgl_prev;
endmodule

// File: rtl/wdog_core.sv
`timescale 1ns/100ps
// Prescaler and base counter in the watchdog domain.
// (2**RATIO_W)-1 must not exceed PRE_W.
module wdog_core #(
  parameter int PRE_W   = 7,
  parameter int BASE_W  = 8,
  parameter int RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               clr,
  input  logic [RATIO_W-1:0] ratio,
  output logic               expire
);
  logic [PRE_W-1:0]  pre_q;
  logic [PRE_W-1:0]  mask;
  logic [BASE_W-1:0] base_q;
  logic              tick;

  always_comb begin
    mask   = PRE_W'((32'd1 << ratio) - 32'd1);
    tick   = (pre_q & mask) == mask;
    // A clear in the same cycle cancels the timeout.
    expire = tick && (&base_q) && !clr;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      pre_q  <= '0;
      base_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (tick) base_q <= base_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdog_top.sv
`timescale 1ns/100ps
module wdog_top
  import wdog_pkg::*;
#(
  parameter bit EN          = 1'b1,
  parameter int PRE_W       = 7,
  parameter int BASE_W      = 8,
  parameter int RATIO_W     = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic               sys_clk,
  input  logic               wd_clk,
  input  logic               por,
  input  logic               clr_req,
  input  logic [RATIO_W-1:0] ratio_sel,
  input  logic               asleep,
  output logic               wd_reset,
  output logic               wake,
  output logic               to_flag
);
  if (EN) begin : g_on
    // ---------- system domain: clear toggle ----------
    logic clr_tgl;
    always_ff @(posedge sys_clk) begin
      if (por)          clr_tgl <= 1'b0;
      else if (clr_req) clr_tgl <= ~clr_tgl;
    end

    // ---------- watchdog domain ----------
    logic               clr_pulse;
    logic [RATIO_W-1:0] ratio_w;
    logic               sleep_w;
    logic               expire;
    logic               to_tgl;
    logic               wake_q;
    to_kind_e           kind_q;

    wdog_tgl_rx #(.STAGES(SYNC_STAGES)) u_clr_rx (
      .clk   (wd_clk),
      .rst   (por),
      .tgl   (clr_tgl),
      .pulse (clr_pulse)
    );

    // Ratio is quasi-static: software changes it only ahead of a clear.
    wdog_sync #(.W(RATIO_W), .STAGES(SYNC_STAGES)) u_ratio_sync (
      .clk (wd_clk),
      .rst (por),
      .d   (ratio_sel),
      .q   (ratio_w)
    );

    wdog_sync #(.W(1), .STAGES(SYNC_STAGES)) u_sleep_sync (
      .clk (wd_clk),
      .rst (por),
      .d   (asleep),
      .q   (sleep_w)
    );

    wdog_core #(.PRE_W(PRE_W), .BASE_W(BASE_W), .RATIO_W(RATIO_W)) u_core (
      .clk    (wd_clk),
      .rst    (por),
      .clr    (clr_pulse),
      .ratio  (ratio_w),
      .expire (expire)
    );

    always_ff @(posedge wd_clk) begin
      if (por) begin
        to_tgl <= 1'b0;
        kind_q <= TO_RESET;
        wake_q <= 1'b0;
      end else begin
        if (expire) begin
          to_tgl <= ~to_tgl;
          kind_q <= sleep_w ? TO_WAKE : TO_RESET;
        end
        if (expire && sleep_w) wake_q <= 1'b1;
        else if (!sleep_w)     wake_q <= 1'b0;
      end
    end

    // ---------- system domain: timeout return ----------
    logic to_ev;
    logic rst_q;
    logic flag_q;

    wdog_tgl_rx #(.STAGES(SYNC_STAGES)) u_to_rx (
      .clk   (sys_clk),
      .rst   (por),
      .tgl   (to_tgl),
      .pulse (to_ev)
    );

    // kind_q is written once per timeout and is stable long before to_ev.
    always_ff @(posedge sys_clk) begin
      if (por) begin
        rst_q  <= 1'b0;
        flag_q <= 1'b0;
      end else begin
        rst_q <= to_ev && (kind_q == TO_RESET);
        if (to_ev)        flag_q <= 1'b1;
        else if (clr_req) flag_q <= 1'b0;
      end
    end

    assign wd_reset = rst_q;
    assign wake     = wake_q;
    assign to_flag  = flag_q;
  end else begin : g_off
    logic unused_inputs;
    assign unused_inputs = ^{sys_clk, wd_clk, por, clr_req, ratio_sel, asleep};
    assign wd_reset = 1'b0;
    assign wake     = 1'b0;
    assign to_flag  = 1'b0;
  end
endmodule

// File: rtl/wdog_chk.sv
`timescale 1ns/100ps
module wdog_chk (
  input logic sys_clk,
  input logic wd_clk,
  input logic por,
  input logic clr_req,
  input logic asleep,
  input logic wd_reset,
  input logic wake,
  input logic to_flag
);
  logic por_sq = 1'b0;
  logic por_wq = 1'b0;

  always_ff @(posedge sys_clk) begin
    if (por_sq) a_por_sys_r1: assert (!wd_reset && !to_flag)
      else $error("R1: system outputs not cleared by por");
    por_sq <= por;
  end

  always_ff @(posedge wd_clk) begin
    if (por_wq) a_por_wd_r1: assert (!wake)
      else $error("R1: wake not cleared by por");
    por_wq <= por;
  end

  p_single_pulse_r4: assert property (@(posedge sys_clk) disable iff (por)
    wd_reset |=> !wd_reset);

  p_pulse_sets_flag_r7: assert property (@(posedge sys_clk) disable iff (por)
    wd_reset |-> to_flag);

  p_flag_sticky_r7: assert property (@(posedge sys_clk) disable iff (por)
    (to_flag && !clr_req) |=> to_flag);

  p_wake_hold_r6: assert property (@(posedge wd_clk) disable iff (por)
    (wake && asleep) |=> wake);
endmodule

bind wdog_top wdog_chk u_chk (
  .sys_clk  (sys_clk),
  .wd_clk   (wd_clk),
  .por      (por),
  .clr_req  (clr_req),
  .asleep   (asleep),
  .wd_reset (wd_reset),
  .wake     (wake),
  .to_flag  (to_flag)
);

// File: tb/wdog_top_bench.sv
`timescale 1ns/100ps
module wdog_top_bench;
  logic       sys_free = 1'b0;
  logic       sys_run  = 1'b1;
  logic       sys_clk;
  logic       wd_clk   = 1'b0;
  logic       por      = 1'b1;
  logic       clr_req  = 1'b0;
  logic [2:0] ratio    = 3'd0;
  logic       asleep   = 1'b0;
  logic       wd_reset, wake, to_flag;
  logic       off_rst, off_wake, off_flag;

  int checks = 0;
  int errors = 0;

  assign sys_clk = sys_free & sys_run;
  always #5 sys_free = ~sys_free;                  // 100 MHz
  initial begin #1.7; forever #16.5 wd_clk = ~wd_clk; end

  wdog_top u_wdog_top (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .por(por), .clr_req(clr_req),
    .ratio_sel(ratio), .asleep(asleep),
    .wd_reset(wd_reset), .wake(wake), .to_flag(to_flag));

  wdog_top #(.EN(1'b0)) u_wdog_top_off (
    .sys_clk(sys_clk), .wd_clk(wd_clk), .por(por), .clr_req(clr_req),
    .ratio_sel(ratio), .asleep(asleep),
    .wd_reset(off_rst), .wake(off_wake), .to_flag(off_flag));

  task automatic chk(input string tag, input string what, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s got %0b expected %0b at %0t", tag, what, got, exp, $time);
    end
  endtask

  task automatic chk_int(input string tag, input string what, input longint got,
                         input longint lo, input longint hi);
    checks++;
    if (got < lo || got > hi) begin
      errors++;
      $display("FAIL %s %s got %0d expected %0d..%0d", tag, what, got, lo, hi);
    end
  endtask

  // ---------------- reference model ----------------
  int   m_cnt = 0, m_pend = 0, m_age = 0, m_spend = 0;
  bit   m_clr_seen = 0, m_sev_new = 0, m_skind = 0;
  bit   m_wake = 0, m_rst = 0, m_flag = 0, m_sl_last = 0;

  // watchdog domain
  always @(posedge wd_clk) begin
    if (por) begin
      m_cnt = 0; m_pend = 0; m_clr_seen = 0; m_wake = 0;
    end else begin
      bit clr_now;
      clr_now = 0;
      if (m_pend > 0) begin m_pend--; if (m_pend == 0) clr_now = 1; end
      if (m_clr_seen) begin m_clr_seen = 0; m_pend = 2; end
      if (clr_now) m_cnt = 0;
      else begin
        m_cnt++;
        if (m_cnt == (256 << ratio)) begin
          m_cnt = 0;
          m_sev_new = 1;
          m_skind = asleep;
          if (asleep) m_wake = 1;
        end
      end
      if (!asleep) m_wake = 0;
    end
    if (asleep != m_sl_last) m_age = 0; else m_age++;
    m_sl_last = asleep;
  end

  // system domain
  always @(posedge sys_clk) begin
    if (por) begin
      m_rst = 0; m_flag = 0; m_spend = 0; m_sev_new = 0;
    end else begin
      bit fire;
      fire = 0;
      if (m_spend > 0) begin m_spend--; if (m_spend == 0) fire = 1; end
      if (m_sev_new) begin m_sev_new = 0; m_spend = 2; end
      m_rst = fire && !m_skind;
      if (fire) m_flag = 1; else if (clr_req) m_flag = 0;
      if (clr_req) m_clr_seen = 1;
    end
  end

  // per-clock comparison, away from the active edges
  int      n_pulse = 0;
  realtime t_rst = 0, t_clr = 0;
  always @(negedge sys_clk) begin
    if (!por) begin
      chk("R4", "wd_reset", wd_reset, m_rst);
      chk("R7", "to_flag", to_flag, m_flag);
      chk("R9", "disabled outputs", off_rst | off_wake | off_flag, 1'b0);
    end
    if (wd_reset) begin n_pulse++; t_rst = $realtime; end
  end

  always @(negedge wd_clk) begin
    if (!por && m_age >= 4) chk("R6", "wake", wake, m_wake);
  end

  task automatic pulse_clr();
    @(negedge sys_free) clr_req = 1'b1;
    @(posedge sys_clk) t_clr = $realtime;
    @(negedge sys_free) clr_req = 1'b0;
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #2_000_000;
    checks++; errors++;
    $display("FAIL R4 watchdog expired got running expected done");
    finish_run();
  end

  initial begin
    repeat (20) @(negedge sys_free);
    por = 1'b0;
    @(negedge sys_free);
    chk("R1", "wd_reset after por", wd_reset, 1'b0);
    chk("R1", "to_flag after por", to_flag, 1'b0);
    chk("R1", "wake after por", wake, 1'b0);

    // R3: regular clears keep the timeout away
    n_pulse = 0;
    repeat (6) begin repeat (400) @(negedge sys_free); pulse_clr(); end
    chk_int("R3", "pulses with regular clears", n_pulse, 0, 0);

    // R2 / R4: ratio 0 timeout
    n_pulse = 0;
    repeat (1000) @(negedge sys_free);
    chk_int("R4", "pulses after one period", n_pulse, 1, 1);
    chk("R7", "to_flag after timeout", to_flag, 1'b1);
    chk_int("R2", "ratio 0 delay ns", longint'(t_rst - t_clr),
            256*33 + 90, 256*33 + 135);

    // R7: clear drops the flag
    pulse_clr();
    @(negedge sys_free);
    chk("R7", "to_flag after clear", to_flag, 1'b0);

    // R2: ratio 1
    ratio = 3'd1;
    repeat (20) @(negedge sys_free);
    n_pulse = 0;
    pulse_clr();
    repeat (1800) @(negedge sys_free);
    chk_int("R2", "ratio 1 pulses", n_pulse, 1, 1);
    chk_int("R2", "ratio 1 delay ns", longint'(t_rst - t_clr),
            512*33 + 90, 512*33 + 135);

    // R5 / R8: timeout during sleep with the system clock stopped
    ratio = 3'd0;
    asleep = 1'b1;
    repeat (20) @(negedge sys_free);
    n_pulse = 0;
    pulse_clr();
    repeat (3) @(negedge sys_free);
    sys_run = 1'b0;
    repeat (300) @(posedge wd_clk);
    #3;
    chk("R8", "wake with sys_clk stopped", wake, 1'b1);
    chk("R5", "wake after sleep timeout", wake, 1'b1);
    @(negedge sys_free) sys_run = 1'b1;
    repeat (10) @(negedge sys_free);
    chk("R8", "to_flag after clock restart", to_flag, 1'b1);
    chk_int("R5", "no reset pulse in sleep", n_pulse, 0, 0);

    // R6: wake drops once sleep ends
    @(negedge sys_free) asleep = 1'b0;
    repeat (6) @(posedge wd_clk);
    @(negedge sys_free);
    chk("R6", "wake after sleep end", wake, 1'b0);

    repeat (800) @(negedge sys_free);
    chk("R9", "disabled wake", off_wake, 1'b0);
    chk("R9", "disabled flag", off_flag, 1'b0);
    finish_run();
  end
endmodule